// File: doc/BRIEF.md
# Serial Shift and Rotate Unit with Carry

This unit moves the bits of a byte or word operand left or right by a count and reports the new carry flag. It has seven operations: two logical shifts, one arithmetic right shift, two plain rotates and two rotates through carry. A reserved eighth code does nothing. A caller places the operand, the width select, the operation, the count source and the incoming carry on the inputs and pulses `start`. The unit then moves the operand by one bit position on each clock. It raises `done` for one cycle when the last step has been applied.

The count comes from one of two inputs: an immediate byte or the value of a count register. Only its five low bits are used, so a run takes from zero to thirty-one steps. Between runs the result and the carry stay on the outputs unchanged. A `start` that arrives while a run is in progress is ignored.

Top module: `shift_rot_unit`

## Requirements
- R1: Operation code 0 is a logical left shift. Zeros enter at bit 0. The carry takes the last bit shifted out of the top, so 5 shifted left by 2 gives 20.
- R2: Operation code 1 is a logical right shift. Zeros enter at the top bit, and the carry takes the last bit shifted out of bit 0.
- R3: Operation code 2 is an arithmetic right shift. The sign bit is copied into the top bit on every step and the carry takes bit 0, so byte 0xB0 (-80) shifted once gives 0xD8 (-40).
- R4: Operation code 3 rotates left. The old top bit goes into both bit 0 and the carry, so byte 0xF0 rotated once gives 0xE1 with carry 1.
- R5: Operation code 4 rotates right. The old bit 0 goes into both the top bit and the carry, so byte 0x3F rotated by 4 gives 0xF3.
- R6: Operation code 5 rotates left through carry. The carry is an extra ring bit: the old top bit goes into the carry and the old carry goes into bit 0.
- R7: Operation code 6 rotates right through carry. The old bit 0 goes into the carry and the old carry goes into the top bit (bit 15 for a word, bit 7 for a byte).
- R8: With `is_word`=0 the unit works on bits 7:0 only, with bit 7 as the top bit, and `result[15:8]` reads 0. With `is_word`=1 all 16 bits take part.
- R9: With `cnt_sel`=0 the count is `cnt_imm`; with `cnt_sel`=1 it is `cnt_reg`. Only the low 5 bits are used (count modulo 32).
- R10: A count of 0 returns the operand unchanged (masked to the selected width) and the carry equal to `cf_in`.
- R11: `done` is high for exactly one cycle. For a count n of 1 or more it is set on the n-th clock edge after the edge that accepted `start`. For a count of 0 it is set on the accepting edge itself.
- R12: A `start` that arrives during a run has no effect. Between runs, `result` and `cf_out` hold their values.
- R13: Operation code 7 is reserved. It leaves the operand and the carry unchanged for any count.
- R14: Synchronous reset clears `result`, `cf_out` and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run when the unit is idle |
| is_word | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| op | input | 3 | Operation code 0..7 |
| cnt_sel | input | 1 | Count source: 0 immediate, 1 register |
| cnt_imm | input | 8 | Immediate count |
| cnt_reg | input | 8 | Count register value |
| data_in | input | 16 | Operand |
| cf_in | input | 1 | Incoming carry flag |
| result | output | 16 | Result of the last run |
| cf_out | output | 1 | Carry flag after the last run |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The bench sweeps every operation code at both widths. It uses counts at and around the operand width: 7, 8, 9, 15, 16, 17 and 31. These expose a byte lane that lets the upper byte leak in, or a through-carry rotate whose ring is one bit short: with such a ring a rotate by 9 of a byte would not return the operand. Counts given with bits set above bit 4 catch a design that uses the full count byte instead of taking it modulo 32. A count of 0 catches a unit that changes the carry or reports `done` late. A `start` pulse sent in the middle of a run catches a sequencer that reloads its operand or its count.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_HOLD = 3'd7
  } sr_op_e;
endpackage

// File: rtl/sr_count_sel.sv
module sr_count_sel #(
  parameter int CW = 8,
  parameter int NW = 5
) (
  input  logic          sel,
  input  logic [CW-1:0] imm_v,
  input  logic [CW-1:0] reg_v,
  output logic [NW-1:0] n
);
  logic [CW-1:0] picked;
  always_comb begin
    picked = sel ? reg_v : imm_v;
    n      = picked[NW-1:0];   // count taken modulo 2**NW
  end
endmodule

// File: rtl/sr_step.sv
module sr_step #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] x,
  input  sr_pkg::sr_op_e op,
  input  logic          cf,
  output logic [LW-1:0] y,
  output logic          ncf
);
  import sr_pkg::*;
  logic top, bot;
  always_comb begin
    top = x[LW-1];
    bot = x[0];
    y   = x;
    ncf = cf;
    unique case (op)
      OP_SHL:  begin y = {x[LW-2:0], 1'b0}; ncf = top; end
      OP_SHR:  begin y = {1'b0, x[LW-1:1]}; ncf = bot; end
      OP_SAR:  begin y = {top,  x[LW-1:1]}; ncf = bot; end
      OP_ROL:  begin y = {x[LW-2:0], top};  ncf = top; end
      OP_ROR:  begin y = {bot,  x[LW-1:1]}; ncf = bot; end
      OP_RCL:  begin y = {x[LW-2:0], cf};   ncf = top; end
      OP_RCR:  begin y = {cf,   x[LW-1:1]}; ncf = bot; end
      default: begin y = x;                 ncf = cf;  end
    endcase
  end
endmodule

// File: rtl/sr_seq.sv
module sr_seq #(
  parameter int W  = 16,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_word,
  input  sr_pkg::sr_op_e op,
  input  logic [NW-1:0] n,
  input  logic [W-1:0]  data_in,
  input  logic          cf_in,
  output logic [W-1:0]  work_q,
  output logic          cf_q,
  output logic          done_q,
  output logic          busy_q,
  output sr_pkg::sr_op_e op_q,
  output logic          word_q
);
  import sr_pkg::*;
  localparam int HW = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{HW{1'b0}}, {HW{1'b1}}};
  localparam int LANES = 2;

  logic [NW-1:0] rem_q;
  logic [W-1:0]  lane_y [LANES];
  logic          lane_c [LANES];
  logic          lane_sel;

  // lane 0 is full width, lane 1 is the byte lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = W >> g;
    logic [LW-1:0] y;
    logic          c;
    sr_step #(.LW(LW)) u_step (
      .x   (work_q[LW-1:0]),
      .op  (op_q),
      .cf  (cf_q),
      .y   (y),
      .ncf (c)
    );
    assign lane_y[g] = W'(y);
    assign lane_c[g] = c;
  end

  assign lane_sel = ~word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      cf_q   <= 1'b0;
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_SHL;
      word_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        work_q <= lane_y[lane_sel];
        cf_q   <= lane_c[lane_sel];
        rem_q  <= rem_q - 1'b1;
        if (rem_q == NW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        op_q   <= op;
        word_q <= is_word;
        work_q <= is_word ? data_in : (data_in & LOW_MASK);
        cf_q   <= cf_in;
        rem_q  <= n;
        if (n == '0) done_q <= 1'b1;
        else         busy_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit #(
  parameter int W  = 16,
  parameter int CW = 8,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_word,
  input  logic [2:0]    op,
  input  logic          cnt_sel,
  input  logic [CW-1:0] cnt_imm,
  input  logic [CW-1:0] cnt_reg,
  input  logic [W-1:0]  data_in,
  input  logic          cf_in,
  output logic [W-1:0]  result,
  output logic          cf_out,
  output logic          done
);
  import sr_pkg::*;
  logic [NW-1:0] cnt_n;
  logic          busy;
  sr_op_e        op_q;
  logic          word_q;
  sr_op_e        op_in;

  assign op_in = sr_op_e'(op);

  sr_count_sel #(.CW(CW), .NW(NW)) u_cnt (
    .sel   (cnt_sel),
    .imm_v (cnt_imm),
    .reg_v (cnt_reg),
    .n     (cnt_n)
  );

  sr_seq #(.W(W), .NW(NW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .is_word (is_word),
    .op      (op_in),
    .n       (cnt_n),
    .data_in (data_in),
    .cf_in   (cf_in),
    .work_q  (result),
    .cf_q    (cf_out),
    .done_q  (done),
    .busy_q  (busy),
    .op_q    (op_q),
    .word_q  (word_q)
  );
endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk #(
  parameter int W  = 16,
  parameter int NW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          is_word,
  input logic [W-1:0]  data_in,
  input logic          cf_in,
  input logic [NW-1:0] cnt_n,
  input logic          busy,
  input logic [2:0]    op_q,
  input logic          word_q,
  input logic [W-1:0]  result,
  input logic          cf_out,
  input logic          done
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{HW{1'b0}}, {HW{1'b1}}};

  // R11: done is a single-cycle pulse unless a new zero-count run is accepted
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R11: done only follows a run step or an accepted start
  p_done_source_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) || $past(start)));

  // R10: zero count returns operand and incoming carry on the accepting edge
  p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cnt_n == '0) |=>
      (done && cf_out == $past(cf_in) &&
       result == ($past(is_word) ? $past(data_in) : ($past(data_in) & LOW_MASK))));

  // R12: captured operation and width are frozen during a run
  p_busy_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_q) && $stable(word_q)));

  // R12: outputs hold while idle without a start
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(result) && $stable(cf_out)));

  // R8: byte runs never touch the upper half
  p_byte_upper_r8: assert property (@(posedge clk) disable iff (rst)
    (!word_q && busy) |=> (result[W-1:HW] == '0));
endmodule

bind shift_rot_unit shift_rot_unit_chk #(.W(W), .NW(NW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .is_word (is_word),
  .data_in (data_in),
  .cf_in   (cf_in),
  .cnt_n   (cnt_n),
  .busy    (busy),
  .op_q    (op_q),
  .word_q  (word_q),
  .result  (result),
  .cf_out  (cf_out),
  .done    (done)
);

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_word = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        cnt_sel = 1'b0;
  logic [7:0]  cnt_imm = 8'd0;
  logic [7:0]  cnt_reg = 8'd0;
  logic [15:0] data_in = 16'd0;
  logic        cf_in = 1'b0;
  logic [15:0] result;
  logic        cf_out;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rst(rst), .start(start), .is_word(is_word), .op(op),
    .cnt_sel(cnt_sel), .cnt_imm(cnt_imm), .cnt_reg(cnt_reg),
    .data_in(data_in), .cf_in(cf_in), .result(result), .cf_out(cf_out),
    .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected values from the requirement text, computed arithmetically
  task automatic model(input int o, input bit w, input int n, input logic [15:0] d,
                       input bit c, output logic [15:0] r, output bit co);
    int wd;
    longint x, m, ring, rr, k;
    wd = w ? 16 : 8;
    m  = (64'd1 << wd) - 1;
    x  = d & m;
    r  = 16'(x);
    co = c;
    if (n == 0 || o == 7) return;
    case (o)
      0: begin r = 16'((x << n) & m); co = (n <= wd) ? x[wd-n] : 1'b0; end
      1: begin r = 16'(x >> n);       co = (n <= wd) ? x[n-1]  : 1'b0; end
      2: begin
        longint sx;
        sx = x[wd-1] ? (x | ~m) : x;
        r  = 16'((sx >>> n) & m);
        co = (n <= wd) ? x[n-1] : x[wd-1];
      end
      3: begin k = n % wd; rr = ((x << k) | (x >> (wd - k))) & m; r = 16'(rr); co = rr[0]; end
      4: begin k = n % wd; rr = ((x >> k) | (x << (wd - k))) & m; r = 16'(rr); co = rr[wd-1]; end
      5, 6: begin
        longint mm;
        mm   = (64'd1 << (wd + 1)) - 1;
        ring = (longint'(c) << wd) | x;
        k    = n % (wd + 1);
        if (o == 5) rr = ((ring << k) | (ring >> (wd + 1 - k))) & mm;
        else        rr = ((ring >> k) | (ring << (wd + 1 - k))) & mm;
        r  = 16'(rr & m);
        co = rr[wd];
      end
      default: ;
    endcase
  endtask

  task automatic run(input int o, input bit w, input bit sel, input logic [7:0] imm,
                     input logic [7:0] rg, input logic [15:0] d, input bit c, output int lat);
    @(negedge clk);
    op = 3'(o); is_word = w; cnt_sel = sel; cnt_imm = imm; cnt_reg = rg;
    data_in = d; cf_in = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_check(input int o, input bit w, input bit sel, input logic [7:0] imm,
                           input logic [7:0] rg, input logic [15:0] d, input bit c,
                           input string tag);
    int lat, n;
    logic [15:0] er;
    bit ec;
    n = sel ? int'(rg[4:0]) : int'(imm[4:0]);
    model(o, w, n, d, c, er, ec);
    run(o, w, sel, imm, rg, d, c, lat);
    check(result == er, {tag, " result"}, result, er);
    check(cf_out == ec, {tag, " carry"}, cf_out, ec);
    check(lat == n, "R11 latency", lat, n);
  endtask

  initial begin
    string tags[8];
    int counts[11];
    logic [15:0] pats[4];
    int lat;
    tags = '{"R1 shl", "R2 shr", "R3 sar", "R4 rol", "R5 ror", "R6 rcl", "R7 rcr", "R13 hold"};
    counts = '{0, 1, 2, 3, 7, 8, 9, 15, 16, 17, 31};
    pats = '{16'h8001, 16'h5A3C, 16'hB0F7, 16'h7FFE};

    repeat (3) @(negedge clk);
    // R14: reset state
    check(result == 16'h0, "R14 result", result, 0);
    check(cf_out == 1'b0, "R14 carry", cf_out, 0);
    check(done == 1'b0, "R14 done", done, 0);
    rst = 1'b0;

    // worked examples
    run_check(0, 1, 0, 8'd2, 8'd0, 16'd5, 0, "R1 five_by_four");
    check(result == 16'd20, "R1 twenty", result, 20);
    run_check(2, 0, 0, 8'd1, 8'd0, 16'h00B0, 0, "R3 minus80");
    check(result == 16'h00D8, "R3 minus40", result, 16'hD8);
    run_check(3, 0, 0, 8'd1, 8'd0, 16'h00F0, 0, "R4 f0");
    check(result == 16'h00E1 && cf_out, "R4 e1", result, 16'hE1);
    run_check(4, 0, 1, 8'd0, 8'd4, 16'h003F, 0, "R5 3f");
    check(result == 16'h00F3, "R5 f3", result, 16'hF3);
    run_check(6, 1, 0, 8'd1, 8'd0, 16'h0001, 0, "R7 b0_to_cf");
    check(result == 16'h0000 && cf_out, "R7 cf_set", result, 0);
    run_check(6, 1, 0, 8'd1, 8'd0, 16'h0000, 1, "R7 cf_to_b15");
    check(result == 16'h8000 && !cf_out, "R7 bit15", result, 16'h8000);
    run_check(5, 0, 0, 8'd1, 8'd0, 16'h0080, 0, "R6 msb_to_cf");
    check(result == 16'h0000 && cf_out, "R6 cf_set", result, 0);
    run_check(5, 0, 0, 8'd1, 8'd0, 16'h0000, 1, "R6 cf_to_b0");
    check(result == 16'h0001 && !cf_out, "R6 bit0", result, 1);
    run_check(0, 0, 0, 8'd0, 8'd0, 16'hABCD, 1, "R10 zero_byte");
    check(result == 16'h00CD && cf_out, "R8 upper_zero", result, 16'hCD);
    run_check(1, 1, 1, 8'd5, 8'h21, 16'h8000, 0, "R9 reg_mod32");
    check(result == 16'h4000, "R9 reg_count_1", result, 16'h4000);
    run_check(1, 1, 0, 8'hE2, 8'd9, 16'h8000, 0, "R9 imm_mod32");
    check(result == 16'h2000, "R9 imm_count_2", result, 16'h2000);

    // R12: start during a run is ignored
    @(negedge clk);
    op = 3'd3; is_word = 1; cnt_sel = 0; cnt_imm = 8'd8; data_in = 16'h0001; cf_in = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = 3'd0; data_in = 16'hFFFF; cnt_imm = 8'd0; cf_in = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check(lat == 8, "R12 latency_kept", lat, 8);
    check(result == 16'h0100, "R12 result_kept", result, 16'h0100);
    check(cf_out == 1'b0, "R12 carry_kept", cf_out, 0);
    repeat (3) begin
      @(negedge clk);
      check(!done, "R11 single_pulse", done, 0);
      check(result == 16'h0100, "R12 hold_idle", result, 16'h0100);
    end

    // sweep
    for (int o = 0; o < 8; o++)
      for (int w = 0; w < 2; w++)
        for (int ci = 0; ci < 11; ci++)
          for (int pi = 0; pi < 4; pi++) begin
            bit sel;
            logic [7:0] cnt8, junk;
            sel  = (ci + pi) % 2 == 1;
            cnt8 = 8'(counts[ci] + 32 * pi);
            junk = 8'(8'h5B + ci);
            if (sel) run_check(o, w[0], 1'b1, junk, cnt8, pats[pi], pi[0], tags[o]);
            else     run_check(o, w[0], 1'b0, cnt8, junk, pats[pi], pi[0], tags[o]);
            if (!w[0]) check(result[15:8] == 8'h00, "R8 byte_upper", result, 0);
          end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule